// File: doc/BRIEF.md
# Vector Response Compare Unit

This block checks, vector by vector, the response captured on a set of bidirectional test channels against the expected data supplied by a pattern sequencer. Each vector brings the captured response bits, the expected reference bits, a compare-enable flag and the vector address. The response is taken on a single clock edge. A static don't-care mask removes pins from the comparison. The per-vector enable removes whole vectors.

For each compared vector the block raises a one-cycle fail flag. It also ORs the failing pins into a sticky per-pin error record and latches the address of the first failing vector. A single host write clears the record and the address. The block can ask the sequencer to halt in one of two ways: on any unmasked mismatch, or only on a mismatch at one programmed pin. The halt request holds until the sequencer acknowledges it.

Top module: `vec_resp_cmp`

## Requirements
- R1: While `rst` is high at a clock edge, every output is zero after that edge.
- R2: The failing pins of a vector are `(vec_resp XOR vec_exp) AND NOT cfg_mask`. A pin whose `cfg_mask` bit is 1 never fails, never sets its `pin_err` bit and never requests a halt.
- R3: A vector sampled with `vec_valid` low or `vec_cmp_en` low has no effect. `vec_fail`, `pin_err`, `first_fail_valid`, `first_fail_addr` and `halt_req` keep their previous values, except that `vec_fail` is low.
- R4: `vec_fail` is high in the cycle after the edge that samples a vector with at least one failing pin, and is low after any other edge.
- R5: `pin_err` ORs in the failing pins of every vector. When `err_clr` is high at an edge, `pin_err` becomes exactly the failing pins of the vector sampled at that edge.
- R6: The first failing vector after reset or after a clear sets `first_fail_valid` and stores its `vec_addr` in `first_fail_addr`. Both then hold until `err_clr`. A vector failing in the same cycle as `err_clr` is recorded as the new first failure.
- R7: `cfg_halt_mode` encodes 0 = no halt, 1 = halt on any failing pin, 2 = halt only on a failing pin at index `cfg_halt_pin`, 3 = no halt. In mode 1, any failing pin sets `halt_req` one clock after its vector is sampled.
- R8: In mode 2, only a failure at pin `cfg_halt_pin` sets `halt_req`. Failures at other pins still drive `vec_fail` and `pin_err`.
- R9: `halt_req` stays high until an edge with `halt_ack` high, which clears it. A halt trigger at the same edge as `halt_ack` keeps it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vec_valid | input | 1 | A vector is presented this cycle |
| vec_addr | input | ADDR_W (20) | Address of the presented vector |
| vec_resp | input | CH (64) | Captured response bits |
| vec_exp | input | CH (64) | Expected reference bits |
| vec_cmp_en | input | 1 | Per-vector compare enable |
| cfg_mask | input | CH (64) | Static don't-care mask, 1 = ignore pin |
| cfg_halt_mode | input | 2 | Halt mode (see R7) |
| cfg_halt_pin | input | PIN_W (6) | Pin index for halt mode 2 |
| err_clr | input | 1 | Host write that clears the error record |
| halt_ack | input | 1 | Sequencer acknowledges the halt request |
| halt_req | output | 1 | Halt request to the sequencer |
| vec_fail | output | 1 | Registered per-vector fail flag |
| pin_err | output | CH (64) | Sticky per-pin error record |
| first_fail_valid | output | 1 | First-failure address is held |
| first_fail_addr | output | ADDR_W (20) | Address of the first failing vector |

## Verification
The checker assumes that the mask, halt mode and halt pin stay fixed while a vector is being compared. It also assumes that every input is driven to a known value from the first clock edge. Several of its properties look back at the inputs of the previous edge through `$past`, and these would lose their meaning if the configuration changed between the sample and the check. The bench changes configuration only between vectors, while `vec_valid` is low, and drives every input from time zero.

// File: rtl/vrc_pkg.sv
package vrc_pkg;
  typedef enum logic [1:0] {
    HALT_OFF  = 2'd0,
    HALT_ANY  = 2'd1,
    HALT_PIN  = 2'd2,
    HALT_RSVD = 2'd3
  } halt_mode_e;
endpackage

// File: rtl/vrc_compare.sv
module vrc_compare #(
  parameter int CH = 64
) (
  input  logic          sample,
  input  logic [CH-1:0] resp,
  input  logic [CH-1:0] expd,
  input  logic [CH-1:0] mask,
  output logic [CH-1:0] fail_bits,
  output logic          any_fail
);
  for (genvar g = 0; g < CH; g++) begin : g_pin
    assign fail_bits[g] = sample & (resp[g] ^ expd[g]) & ~mask[g];
  end
  assign any_fail = |fail_bits;
endmodule

// File: rtl/vrc_err_log.sv
module vrc_err_log #(
  parameter int CH     = 64,
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [CH-1:0]     fail_bits,
  input  logic              any_fail,
  input  logic [ADDR_W-1:0] addr,
  output logic [CH-1:0]     sticky,
  output logic              first_valid,
  output logic [ADDR_W-1:0] first_addr,
  output logic              fail_flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sticky      <= '0;
      first_valid <= 1'b0;
      first_addr  <= '0;
      fail_flag   <= 1'b0;
    end else begin
      fail_flag <= any_fail;
      sticky    <= clr ? fail_bits : (sticky | fail_bits);
      if (clr) begin
        first_valid <= any_fail;
        first_addr  <= any_fail ? addr : '0;
      end else if (any_fail && !first_valid) begin
        first_valid <= 1'b1;
        first_addr  <= addr;
      end
    end
  end
endmodule

// File: rtl/vrc_halt_ctrl.sv
module vrc_halt_ctrl
  import vrc_pkg::*;
#(
  parameter int CH    = 64,
  parameter int PIN_W = $clog2(CH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic [PIN_W-1:0] pin_sel,
  input  logic [CH-1:0]    fail_bits,
  input  logic             any_fail,
  input  logic             ack,
  output logic             req
);
  halt_mode_e mode_e;
  logic       trig;

  always_comb begin
    mode_e = halt_mode_e'(mode);
    case (mode_e)
      HALT_ANY: trig = any_fail;
      HALT_PIN: trig = fail_bits[pin_sel];
      default:  trig = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       req <= 1'b0;
    else if (trig) req <= 1'b1;
    else if (ack)  req <= 1'b0;
  end
endmodule

// File: rtl/vec_resp_cmp.sv
module vec_resp_cmp #(
  parameter int CH     = 64,
  parameter int ADDR_W = 20,
  parameter int PIN_W  = $clog2(CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vec_valid,
  input  logic [ADDR_W-1:0] vec_addr,
  input  logic [CH-1:0]     vec_resp,
  input  logic [CH-1:0]     vec_exp,
  input  logic              vec_cmp_en,
  input  logic [CH-1:0]     cfg_mask,
  input  logic [1:0]        cfg_halt_mode,
  input  logic [PIN_W-1:0]  cfg_halt_pin,
  input  logic              err_clr,
  input  logic              halt_ack,
  output logic              halt_req,
  output logic              vec_fail,
  output logic [CH-1:0]     pin_err,
  output logic              first_fail_valid,
  output logic [ADDR_W-1:0] first_fail_addr
);
  logic [CH-1:0] fail_bits;
  logic          any_fail;
  logic          sample;

  assign sample = vec_valid & vec_cmp_en;

  vrc_compare #(.CH(CH)) u_cmp (
    .sample(sample), .resp(vec_resp), .expd(vec_exp), .mask(cfg_mask),
    .fail_bits(fail_bits), .any_fail(any_fail)
  );

  vrc_err_log #(.CH(CH), .ADDR_W(ADDR_W)) u_log (
    .clk(clk), .rst(rst), .clr(err_clr), .fail_bits(fail_bits),
    .any_fail(any_fail), .addr(vec_addr), .sticky(pin_err),
    .first_valid(first_fail_valid), .first_addr(first_fail_addr),
    .fail_flag(vec_fail)
  );

  vrc_halt_ctrl #(.CH(CH), .PIN_W(PIN_W)) u_halt (
    .clk(clk), .rst(rst), .mode(cfg_halt_mode), .pin_sel(cfg_halt_pin),
    .fail_bits(fail_bits), .any_fail(any_fail), .ack(halt_ack), .req(halt_req)
  );
endmodule

// File: rtl/vec_resp_cmp_chk.sv
module vec_resp_cmp_chk #(
  parameter int CH     = 64,
  parameter int ADDR_W = 20,
  parameter int PIN_W  = $clog2(CH)
) (
  input logic              clk,
  input logic              rst,
  input logic              vec_valid,
  input logic [CH-1:0]     vec_resp,
  input logic [CH-1:0]     vec_exp,
  input logic              vec_cmp_en,
  input logic [CH-1:0]     cfg_mask,
  input logic [1:0]        cfg_halt_mode,
  input logic              err_clr,
  input logic              halt_ack,
  input logic              halt_req,
  input logic              vec_fail,
  input logic [CH-1:0]     pin_err,
  input logic              first_fail_valid,
  input logic [ADDR_W-1:0] first_fail_addr
);
  // R3 / R4: a fail flag needs an enabled, valid vector one edge earlier
  a_r4_fail_needs_vector: assert property (@(posedge clk) disable iff (rst)
    vec_fail |-> $past(vec_valid && vec_cmp_en));

  // R2: a fail flag needs an unmasked mismatch in the sampled vector
  a_r2_fail_needs_unmasked: assert property (@(posedge clk) disable iff (rst)
    vec_fail |-> $past(|((vec_resp ^ vec_exp) & ~cfg_mask)));

  // R5: without a clear, no sticky bit ever drops
  a_r5_sticky_keeps: assert property (@(posedge clk) disable iff (rst)
    !err_clr |=> ((pin_err & $past(pin_err)) == $past(pin_err)));

  // R6: a held first-failure address stays until a clear
  a_r6_first_holds: assert property (@(posedge clk) disable iff (rst)
    (first_fail_valid && !err_clr) |=> (first_fail_valid && $stable(first_fail_addr)));

  // R7: a new halt request needs a compared vector and a halting mode
  a_r7_halt_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(halt_req) |-> $past(vec_valid && vec_cmp_en &&
                              (cfg_halt_mode == 2'd1 || cfg_halt_mode == 2'd2)));

  // R9: the halt request holds while it is not acknowledged
  a_r9_halt_holds: assert property (@(posedge clk) disable iff (rst)
    (halt_req && !halt_ack) |=> halt_req);
endmodule

bind vec_resp_cmp vec_resp_cmp_chk #(.CH(CH), .ADDR_W(ADDR_W), .PIN_W(PIN_W)) u_chk (
  .clk(clk), .rst(rst), .vec_valid(vec_valid), .vec_resp(vec_resp),
  .vec_exp(vec_exp), .vec_cmp_en(vec_cmp_en), .cfg_mask(cfg_mask),
  .cfg_halt_mode(cfg_halt_mode), .err_clr(err_clr), .halt_ack(halt_ack),
  .halt_req(halt_req), .vec_fail(vec_fail), .pin_err(pin_err),
  .first_fail_valid(first_fail_valid), .first_fail_addr(first_fail_addr)
);

// File: tb/vec_resp_cmp_tb.sv
module vec_resp_cmp_tb;
  localparam int CH = 64, AW = 20, PW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          vec_valid = 1'b0, vec_cmp_en = 1'b0, err_clr = 1'b0, halt_ack = 1'b0;
  logic [AW-1:0] vec_addr = '0;
  logic [CH-1:0] vec_resp = '0, vec_exp = '0, cfg_mask = '0;
  logic [1:0]    cfg_halt_mode = 2'd0;
  logic [PW-1:0] cfg_halt_pin = '0;
  logic          halt_req, vec_fail, first_fail_valid;
  logic [CH-1:0] pin_err;
  logic [AW-1:0] first_fail_addr;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  vec_resp_cmp u_dut (
    .clk(clk), .rst(rst), .vec_valid(vec_valid), .vec_addr(vec_addr),
    .vec_resp(vec_resp), .vec_exp(vec_exp), .vec_cmp_en(vec_cmp_en),
    .cfg_mask(cfg_mask), .cfg_halt_mode(cfg_halt_mode), .cfg_halt_pin(cfg_halt_pin),
    .err_clr(err_clr), .halt_ack(halt_ack), .halt_req(halt_req),
    .vec_fail(vec_fail), .pin_err(pin_err), .first_fail_valid(first_fail_valid),
    .first_fail_addr(first_fail_addr)
  );

  task automatic chk(input string tag, input logic [CH-1:0] act, input logic [CH-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one vector: drive at negedge, sampled at posedge, outputs read at next negedge
  task automatic apply(input logic [AW-1:0] a, input logic [CH-1:0] r,
                       input logic [CH-1:0] e, input logic en, input logic clr);
    vec_valid = 1'b1; vec_addr = a; vec_resp = r; vec_exp = e;
    vec_cmp_en = en; err_clr = clr;
    @(negedge clk);
    vec_valid = 1'b0; vec_cmp_en = 1'b0; err_clr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [CH-1:0] m, exp_err, pat;
    logic [AW-1:0] exp_first;
    logic          exp_fv;
    @(negedge clk); @(negedge clk);
    // R1: reset state
    chk("R1 halt_req", {63'd0, halt_req}, '0);
    chk("R1 vec_fail", {63'd0, vec_fail}, '0);
    chk("R1 pin_err", pin_err, '0);
    chk("R1 first", {43'd0, first_fail_valid, first_fail_addr}, '0);
    rst = 1'b0;
    @(negedge clk);

    // Sweep every pin, masks on every third pin; mode 0 so no halt
    m = '0;
    for (int p = 0; p < CH; p++) if (p % 3 == 0) m[p] = 1'b1;
    cfg_mask = m;
    exp_err = '0; exp_fv = 1'b0; exp_first = '0;
    for (int p = 0; p < CH; p++) begin
      pat = '0; pat[p] = 1'b1;
      apply(AW'(p + 100), pat ^ {CH{p[0]}}, {CH{p[0]}}, 1'b1, 1'b0);
      // R2 / R4: only unmasked pins fail
      chk("R4 vec_fail sweep", {63'd0, vec_fail}, {63'd0, !m[p]});
      if (!m[p]) begin
        exp_err[p] = 1'b1;
        if (!exp_fv) begin exp_fv = 1'b1; exp_first = AW'(p + 100); end
      end
      chk("R2 R5 pin_err sweep", pin_err, exp_err);
      chk("R6 first sweep", {43'd0, first_fail_valid, first_fail_addr}, {43'd0, exp_fv, exp_first});
      chk("R7 mode0 no halt", {63'd0, halt_req}, '0);
      // R3: disabled vector with all pins mismatching changes nothing
      apply(AW'(7), '1, '0, 1'b0, 1'b0);
      chk("R3 disabled vec_fail", {63'd0, vec_fail}, '0);
      chk("R3 disabled pin_err", pin_err, exp_err);
      chk("R3 disabled first", {44'd0, first_fail_addr}, {44'd0, exp_first});
    end
    // R4: vec_fail drops after an idle edge
    idle(1);
    chk("R4 vec_fail pulse", {63'd0, vec_fail}, '0);
    // R3: mismatch on an invalid cycle
    vec_resp = '1; vec_exp = '0; vec_cmp_en = 1'b1; @(negedge clk); vec_cmp_en = 1'b0;
    chk("R3 invalid pin_err", pin_err, exp_err);
    // matching vector
    apply(AW'(9), 64'hA5A5, 64'hA5A5, 1'b1, 1'b0);
    chk("R4 match no fail", {63'd0, vec_fail}, '0);

    // R5 / R6: clear together with a failing vector
    cfg_mask = '0;
    apply(AW'(20'hABCDE), 64'h0000_0100, 64'h0, 1'b1, 1'b1);
    chk("R5 clear with fail", pin_err, 64'h0000_0100);
    chk("R6 first after clear", {43'd0, first_fail_valid, first_fail_addr}, {43'd0, 1'b1, 20'hABCDE});
    apply(AW'(3), 64'h8000_0000_0000_0001, 64'h0, 1'b1, 1'b0);
    chk("R5 accumulate", pin_err, 64'h8000_0000_0000_0101);
    chk("R6 first held", {44'd0, first_fail_addr}, {44'd0, 20'hABCDE});
    apply(AW'(4), '0, '0, 1'b0, 1'b1);
    chk("R5 clear only", pin_err, '0);
    chk("R6 clear only", {63'd0, first_fail_valid}, '0);

    // R7: any mode
    cfg_halt_mode = 2'd1;
    apply(AW'(5), 64'h20, 64'h0, 1'b1, 1'b0);
    chk("R7 any halt", {63'd0, halt_req}, 64'd1);
    idle(3);
    chk("R9 halt held", {63'd0, halt_req}, 64'd1);
    halt_ack = 1'b1; @(negedge clk); halt_ack = 1'b0;
    chk("R9 ack clears", {63'd0, halt_req}, '0);
    // R9: trigger with ack keeps it set
    halt_ack = 1'b1; apply(AW'(6), 64'h1, 64'h0, 1'b1, 1'b0); halt_ack = 1'b0;
    chk("R9 trigger beats ack", {63'd0, halt_req}, 64'd1);
    halt_ack = 1'b1; @(negedge clk); halt_ack = 1'b0;

    // R8: pin mode, sweep the selected pin against a failure at pin 5
    cfg_halt_mode = 2'd2;
    for (int s = 0; s < CH; s++) begin
      cfg_halt_pin = PW'(s);
      apply(AW'(s), 64'h20, 64'h0, 1'b1, 1'b0);
      chk("R8 pin select", {63'd0, halt_req}, {63'd0, s == 5});
      chk("R8 vec_fail still", {63'd0, vec_fail}, 64'd1);
      halt_ack = 1'b1; @(negedge clk); halt_ack = 1'b0;
    end
    // R2 / R8: masked selected pin never halts
    cfg_halt_pin = PW'(7); cfg_mask = 64'h80;
    apply(AW'(1), 64'h80, 64'h0, 1'b1, 1'b0);
    chk("R2 masked pin no halt", {63'd0, halt_req}, '0);
    // R7: mode 3 never halts
    cfg_mask = '0; cfg_halt_mode = 2'd3;
    apply(AW'(2), '1, '0, 1'b1, 1'b0);
    chk("R7 mode3 no halt", {63'd0, halt_req}, '0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule